// File: doc/BRIEF.md
# SD Host Command Register Front End

This block is the register-facing command path of an SD host controller. Software fills an argument register, then writes the command register with the launch bit set. The block then holds a request towards a simplified card-side port: command index, argument and a request strobe. It waits there until the card side returns a reply that carries a byte length and up to sixteen bytes of payload.

When the reply arrives, the block compares its length with the response type named in the command word. A good reply is loaded into a bank of four 32-bit response words. For a long reply the words are stored in reverse order. A bad reply sets a failure flag in the command register and a command-timeout bit in the status register.

The status register is cleared by writing ones. A single interrupt line is raised while any of the three interrupt-class status bits is set. The block also holds plain configuration, power, debug-mode, byte-count and block-count registers for the rest of the host.

Top module: `sdcr_top`

## Requirements
- R1: After reset, the command, argument, status, config, byte-count, block-count and power registers read 0, the debug-mode register reads 0x0000C60F, and both `irq` and `req_valid` are low.
- R2: The argument register at 0x04 and the byte-count register at 0x3C store all 32 bits. The power register at 0x30 stores bit 0 only. The config register at 0x38 stores bits 10:0. The block-count register at 0x50 stores bits 8:0.
- R3: A write to the command register at 0x00 with bit 15 set raises `req_valid` on the next cycle, with `req_index` equal to command bits 5:0 and `req_arg` equal to the argument register. Bit 15 then reads 1 until the cycle after `rsp_valid`, when both bit 15 and `req_valid` drop.
- R4: A 4-byte reply is accepted when command bit 10 (no response) and bit 9 (long response) are clear. It loads bytes 0..3 into response word 0 at 0x10 (byte 0 is the most significant byte, carried on `rsp_data[127:120]`) and clears words 1..3 at 0x14, 0x18 and 0x1C.
- R5: A 16-byte reply is accepted when response is expected. Word 0 takes bytes 12..15, word 1 takes bytes 8..11, word 2 takes bytes 4..7 and word 3 takes bytes 0..3, each with its lowest-numbered byte in the most significant position.
- R6: With a response expected, a reply is a failure when it has length 0, when it has length 4 while bit 9 is set, or when its length is neither 4 nor 16. A reply with `rsp_err` high is also a failure. A failure sets command bit 14 and status bit 6 and leaves the response words unchanged.
- R7: With command bit 10 set, a reply of any length and no error completes without failure and leaves the response words unchanged.
- R8: A successful command with bit 11 (busy-wait) set sets status bit 10 when config bit 10 is set. It sets nothing when config bit 10 is clear.
- R9: A write to the status register at 0x20 clears exactly the bits written as 1.
- R10: `irq` is high exactly while any of status bits 10, 9 or 8 is set.
- R11: A write to the debug-mode register at 0x34 whose bits 3:0 are 0xF stores 0 in those bits. Every other written value is stored unchanged.
- R12: Reads from offsets other than those named above return 0, and writes to them change no register.
- R13: A write to the command register while a command is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is 0 when low |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| req_valid | output | 1 | Command outstanding towards the card side |
| req_index | output | 6 | Command index of the outstanding command |
| req_arg | output | 32 | Argument of the outstanding command |
| rsp_valid | input | 1 | Card side delivers its reply this cycle |
| rsp_err | input | 1 | Card side reports that no reply could be produced |
| rsp_len | input | 5 | Reply length in bytes |
| rsp_data | input | 128 | Reply bytes, byte 0 in bits 127:120 |
| irq | output | 1 | Interrupt request |

## Verification
A wrong launch state shows up one cycle after the command write. Either `req_valid` fails to rise, or it stays high after the reply and bit 15 of the command register keeps reading 1. A wrong length decision shows up on the first register read after the reply. The command word then has the wrong bit 14, status has the wrong bit 6, or the response bank changes when it should hold. A misordered bank is visible only with a long reply whose four words are all distinct, so the long-reply test uses such a pattern. A status bit that is kept or set wrongly reaches `irq` in the same cycle it is registered.

// File: rtl/sdcr_pkg.sv
package sdcr_pkg;
    localparam int DATA_W = 32;
    localparam int RSP_WORDS = 4;
    localparam int CMD_W = 16;

    // register offsets
    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_ARG  = 8'h04;
    localparam logic [7:0] OFS_RSP0 = 8'h10;
    localparam logic [7:0] OFS_RSP1 = 8'h14;
    localparam logic [7:0] OFS_RSP2 = 8'h18;
    localparam logic [7:0] OFS_RSP3 = 8'h1C;
    localparam logic [7:0] OFS_STS  = 8'h20;
    localparam logic [7:0] OFS_PWR  = 8'h30;
    localparam logic [7:0] OFS_DBG  = 8'h34;
    localparam logic [7:0] OFS_CFG  = 8'h38;
    localparam logic [7:0] OFS_BCT  = 8'h3C;
    localparam logic [7:0] OFS_BLC  = 8'h50;

    // command word bits
    localparam int CB_GO    = 15;
    localparam int CB_FAIL  = 14;
    localparam int CB_BUSY  = 11;
    localparam int CB_NORSP = 10;
    localparam int CB_LONG  = 9;

    // status bits
    localparam int SB_TOUT  = 6;
    localparam int SB_BUSY  = 10;
    localparam int SB_IRQLO = 8;
    localparam int SB_IRQHI = 10;

    localparam int CFG_BUSY_EN = 10;

    localparam logic [DATA_W-1:0] DBG_RESET = 32'h0000_C60F;

    typedef struct packed {
        logic [CMD_W-1:0]                  cmd;
        logic                              pend;
        logic [RSP_WORDS*DATA_W-1:0]       rsp;
    } launch_t;
endpackage

// File: rtl/sdcr_launch.sv
module sdcr_launch
    import sdcr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_we,
    input  logic [CMD_W-1:0]            cmd_wdata,
    input  logic                        rsp_valid,
    input  logic                        rsp_err,
    input  logic [4:0]                  rsp_len,
    input  logic [RSP_WORDS*DATA_W-1:0] rsp_data,
    output logic [CMD_W-1:0]            cmd_q,
    output logic                        pend_q,
    output logic [RSP_WORDS*DATA_W-1:0] rsp_q,
    output logic                        ev_fail,
    output logic                        ev_busy
);
    launch_t st_d, st_q;
    logic    want, bad;

    always_comb begin
        st_d    = st_q;
        ev_fail = 1'b0;
        ev_busy = 1'b0;
        want    = !st_q.cmd[CB_NORSP];
        bad     = rsp_err
                | (want & ((rsp_len == 5'd0)
                         | ((rsp_len == 5'd4) & st_q.cmd[CB_LONG])
                         | ((rsp_len != 5'd4) & (rsp_len != 5'd16))));
        if (!st_q.pend) begin
            if (cmd_we) begin
                st_d.cmd  = cmd_wdata;
                st_d.pend = cmd_wdata[CB_GO];
            end
        end else if (rsp_valid) begin
            st_d.pend       = 1'b0;
            st_d.cmd[CB_GO] = 1'b0;
            if (bad) begin
                st_d.cmd[CB_FAIL] = 1'b1;
                ev_fail           = 1'b1;
            end else begin
                ev_busy = st_q.cmd[CB_BUSY];
                if (want) begin
                    if (rsp_len == 5'd4) begin
                        st_d.rsp = '0;
                        st_d.rsp[DATA_W-1:0] = rsp_data[RSP_WORDS*DATA_W-1 -: DATA_W];
                    end else begin
                        // word k takes bytes 12-4k..15-4k, i.e. lane k of the payload
                        st_d.rsp = rsp_data;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_q  = st_q.cmd;
    assign pend_q = st_q.pend;
    assign rsp_q  = st_q.rsp;
endmodule

// File: rtl/sdcr_status.sv
module sdcr_status
    import sdcr_pkg::*;
#(
    parameter int STS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_mask,
    input  logic [STS_W-1:0] set_mask,
    output logic [STS_W-1:0] sts_q,
    output logic             irq
);
    logic [STS_W-1:0] sts_d;

    always_comb begin
        sts_d = sts_q;
        if (clr_we) sts_d = sts_d & ~clr_mask;
        sts_d = sts_d | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign irq = |sts_q[SB_IRQHI:SB_IRQLO];
endmodule

// File: rtl/sdcr_top.sv
module sdcr_top
    import sdcr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CFG_W  = 11,
    parameter int BLK_W  = 9,
    parameter int STS_W  = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic                        req_valid,
    output logic [5:0]                  req_index,
    output logic [DATA_W-1:0]           req_arg,
    input  logic                        rsp_valid,
    input  logic                        rsp_err,
    input  logic [4:0]                  rsp_len,
    input  logic [RSP_WORDS*DATA_W-1:0] rsp_data,
    output logic                        irq
);
    typedef struct packed {
        logic [DATA_W-1:0] arg;
        logic              pwr;
        logic [DATA_W-1:0] dbg;
        logic [CFG_W-1:0]  cfg;
        logic [DATA_W-1:0] bct;
        logic [BLK_W-1:0]  blc;
    } regs_t;

    regs_t r_d, r_q;
    logic [CMD_W-1:0]            cmd_q;
    logic                        pend_q;
    logic [RSP_WORDS*DATA_W-1:0] rsp_words;
    logic                        ev_fail, ev_busy;
    logic [STS_W-1:0]            sts_q, set_mask;
    logic [DATA_W-1:0]           dbg_w;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (hit(addr, OFS_ARG)) r_d.arg = wdata;
            if (hit(addr, OFS_PWR)) r_d.pwr = wdata[0];
            if (hit(addr, OFS_CFG)) r_d.cfg = wdata[CFG_W-1:0];
            if (hit(addr, OFS_BCT)) r_d.bct = wdata;
            if (hit(addr, OFS_BLC)) r_d.blc = wdata[BLK_W-1:0];
            if (hit(addr, OFS_DBG)) begin
                r_d.dbg = wdata;
                if (wdata[3:0] == 4'hF) r_d.dbg[3:0] = 4'h0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dbg <= DBG_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    sdcr_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (wr_en && hit(addr, OFS_CMD)),
        .cmd_wdata (wdata[CMD_W-1:0]),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_len   (rsp_len),
        .rsp_data  (rsp_data),
        .cmd_q     (cmd_q),
        .pend_q    (pend_q),
        .rsp_q     (rsp_words),
        .ev_fail   (ev_fail),
        .ev_busy   (ev_busy)
    );

    always_comb begin
        set_mask          = '0;
        set_mask[SB_TOUT] = ev_fail;
        set_mask[SB_BUSY] = ev_busy & r_q.cfg[CFG_BUSY_EN];
    end

    sdcr_status #(.STS_W(STS_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (wr_en && hit(addr, OFS_STS)),
        .clr_mask (wdata[STS_W-1:0]),
        .set_mask (set_mask),
        .sts_q    (sts_q),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if      (hit(addr, OFS_CMD))  rdata = DATA_W'(cmd_q);
            else if (hit(addr, OFS_ARG))  rdata = r_q.arg;
            else if (hit(addr, OFS_RSP0)) rdata = rsp_words[0*DATA_W +: DATA_W];
            else if (hit(addr, OFS_RSP1)) rdata = rsp_words[1*DATA_W +: DATA_W];
            else if (hit(addr, OFS_RSP2)) rdata = rsp_words[2*DATA_W +: DATA_W];
            else if (hit(addr, OFS_RSP3)) rdata = rsp_words[3*DATA_W +: DATA_W];
            else if (hit(addr, OFS_STS))  rdata = DATA_W'(sts_q);
            else if (hit(addr, OFS_PWR))  rdata = DATA_W'(r_q.pwr);
            else if (hit(addr, OFS_DBG))  rdata = r_q.dbg;
            else if (hit(addr, OFS_CFG))  rdata = DATA_W'(r_q.cfg);
            else if (hit(addr, OFS_BCT))  rdata = r_q.bct;
            else if (hit(addr, OFS_BLC))  rdata = DATA_W'(r_q.blc);
        end
    end

    assign dbg_w     = r_q.dbg;
    assign req_valid = pend_q;
    assign req_index = cmd_q[5:0];
    assign req_arg   = r_q.arg;
endmodule

// File: rtl/sdcr_chk.sv
module sdcr_chk
    import sdcr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STS_W  = 11
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic                        req_valid,
    input logic                        rsp_valid,
    input logic                        rsp_err,
    input logic [4:0]                  rsp_len,
    input logic [CMD_W-1:0]            cmd_q,
    input logic [STS_W-1:0]            sts_q,
    input logic [DATA_W-1:0]           dbg_q,
    input logic [RSP_WORDS*DATA_W-1:0] rsp_words,
    input logic                        irq
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> req_valid); // R3

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid) |=> (!req_valid && !cmd_q[CB_GO])); // R3

    AST_SHORT_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && !rsp_err && rsp_len == 5'd4
         && !cmd_q[CB_NORSP] && !cmd_q[CB_LONG])
        |=> (rsp_words[RSP_WORDS*DATA_W-1:DATA_W] == '0)); // R4

    AST_FAIL_WITH_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_q[CB_FAIL]) && !$past(wr_en && addr == ADDR_W'(OFS_CMD)))
        |-> sts_q[SB_TOUT]); // R6

    AST_NORSP_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && cmd_q[CB_NORSP]) |=> $stable(rsp_words)); // R7

    AST_IRQ_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rsp_valid)); // R8

    AST_DBG_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DBG)) |=> (dbg_q[3:0] != 4'hF)); // R11
endmodule

bind sdcr_top sdcr_chk #(.ADDR_W(ADDR_W), .STS_W(STS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_len   (rsp_len),
    .cmd_q     (cmd_q),
    .sts_q     (sts_q),
    .dbg_q     (dbg_w),
    .rsp_words (rsp_words),
    .irq       (irq)
);

// File: tb/sdcr_top_tb_top.sv
module sdcr_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en, rd_en;
    logic [7:0]   addr;
    logic [31:0]  wdata, rdata;
    logic         req_valid;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_valid, rsp_err;
    logic [4:0]   rsp_len;
    logic [127:0] rsp_data;
    logic         irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // 8 time units per cycle: 125 MHz with a 1 ns unit
    always #4 clk = ~clk;

    sdcr_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_valid(req_valid), .req_index(req_index),
        .req_arg(req_arg), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_len(rsp_len), .rsp_data(rsp_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rd_en) begin
            if (exp_q.size() == 0) chk("scoreboard empty", rdata, 32'hxxxx_xxxx);
            else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic reply(input logic [4:0] len, input logic err, input logic [127:0] d);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_len = len; rsp_err = err; rsp_data = d;
        @(posedge clk);
        #1 rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    task automatic issue(input logic [15:0] c, input logic [4:0] len, input logic err,
                         input logic [127:0] d);
        wr(8'h00, {16'h0, c});
        reply(len, err, d);
    endtask

    task automatic bank(input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] w2, input logic [31:0] w3, input string tag);
        rd(8'h10, w0, tag);
        rd(8'h14, w1, tag);
        rd(8'h18, w2, tag);
        rd(8'h1C, w3, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        rsp_valid = 1'b0; rsp_err = 1'b0; rsp_len = '0; rsp_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk); #1;
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 req_valid", {31'h0, req_valid}, 32'h0);
        rd(8'h00, 32'h0, "R1 cmd");
        rd(8'h04, 32'h0, "R1 arg");
        rd(8'h20, 32'h0, "R1 status");
        rd(8'h30, 32'h0, "R1 power");
        rd(8'h34, 32'h0000_C60F, "R1 debug");
        rd(8'h38, 32'h0, "R1 config");
        rd(8'h3C, 32'h0, "R1 bytecount");
        rd(8'h50, 32'h0, "R1 blockcount");

        // R2 register storage
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h8765_4321);
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h04, 32'hDEAD_BEEF, "R2 arg");
        rd(8'h30, 32'h1, "R2 power");
        rd(8'h38, 32'h7FF, "R2 config");
        rd(8'h3C, 32'h8765_4321, "R2 bytecount");
        rd(8'h50, 32'h1FF, "R2 blockcount");

        // R12 unmapped offsets
        wr(8'h08, 32'h1111_1111);
        wr(8'h0C, 32'h2222_2222);
        wr(8'h40, 32'h3333_3333);
        wr(8'h44, 32'h4444_4444);
        rd(8'h08, 32'h0, "R12 read 0x08");
        rd(8'h40, 32'h0, "R12 read 0x40");
        rd(8'h44, 32'h0, "R12 read 0x44");
        rd(8'h04, 32'hDEAD_BEEF, "R12 arg untouched");
        rd(8'h3C, 32'h8765_4321, "R12 bytecount untouched");
        rd(8'h00, 32'h0, "R12 cmd untouched");

        // R11 debug nibble
        wr(8'h34, 32'h1234_567F);
        rd(8'h34, 32'h1234_5670, "R11 nibble F stored as 0");
        wr(8'h34, 32'hABCD_0005);
        rd(8'h34, 32'hABCD_0005, "R11 other value kept");

        // R3 / R5 long reply
        wr(8'h38, 32'h0);
        wr(8'h04, 32'h1122_3344);
        wr(8'h00, 32'h0000_8202);
        @(negedge clk); #1;
        chk("R3 req_valid high", {31'h0, req_valid}, 32'h1);
        chk("R3 req_index", {26'h0, req_index}, 32'h2);
        chk("R3 req_arg", req_arg, 32'h1122_3344);
        rd(8'h00, 32'h0000_8202, "R3 go bit while pending");
        wr(8'h00, 32'h0000_0022);
        rd(8'h00, 32'h0000_8202, "R13 write ignored while pending");
        @(negedge clk); #1;
        chk("R3 req_valid still held", {31'h0, req_valid}, 32'h1);
        reply(5'd16, 1'b0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF);
        @(negedge clk); #1;
        chk("R3 req_valid dropped", {31'h0, req_valid}, 32'h0);
        rd(8'h00, 32'h0000_0202, "R3 go bit cleared");
        bank(32'hCCDD_EEFF, 32'h8899_AABB, 32'h4455_6677, 32'h0011_2233, "R5 long order");
        rd(8'h20, 32'h0, "R5 no status");

        // R4 short reply clears upper words
        issue(16'h8011, 5'd4, 1'b0, {32'hA1B2_C3D4, 96'h5555_6666_7777_8888_9999_AAAA});
        rd(8'h00, 32'h0000_0011, "R4 cmd done");
        bank(32'hA1B2_C3D4, 32'h0, 32'h0, 32'h0, "R4 short load");

        // R6 failures
        issue(16'h8203, 5'd4, 1'b0, 128'hFFFF);
        rd(8'h00, 32'h0000_4203, "R6 short for long");
        rd(8'h20, 32'h40, "R6 timeout status");
        chk("R6 irq stays low", {31'h0, irq}, 32'h0);
        bank(32'hA1B2_C3D4, 32'h0, 32'h0, 32'h0, "R6 bank kept");
        wr(8'h20, 32'h7FF);
        issue(16'h8005, 5'd0, 1'b0, 128'h0);
        rd(8'h00, 32'h0000_4005, "R6 empty reply");
        wr(8'h20, 32'h7FF);
        issue(16'h8006, 5'd8, 1'b0, 128'h1234);
        rd(8'h00, 32'h0000_4006, "R6 odd length");
        rd(8'h20, 32'h40, "R6 odd length status");
        wr(8'h20, 32'h7FF);
        issue(16'h8409, 5'd0, 1'b1, 128'h0);
        rd(8'h00, 32'h0000_4409, "R6 card error");
        wr(8'h20, 32'h7FF);

        // R7 no response
        issue(16'h8407, 5'd16, 1'b0, {4{32'h0BAD_0BAD}});
        rd(8'h00, 32'h0000_0407, "R7 no fail");
        rd(8'h20, 32'h0, "R7 no status");
        bank(32'hA1B2_C3D4, 32'h0, 32'h0, 32'h0, "R7 bank kept");

        // R8 busy-wait gated by config
        issue(16'h8C08, 5'd0, 1'b0, 128'h0);
        rd(8'h20, 32'h0, "R8 busy without enable");
        wr(8'h38, 32'h400);
        issue(16'h8C08, 5'd0, 1'b0, 128'h0);
        rd(8'h20, 32'h400, "R8 busy with enable");
        @(negedge clk); #1;
        chk("R10 irq high", {31'h0, irq}, 32'h1);

        // R9 / R10 clearing
        issue(16'h8203, 5'd4, 1'b0, 128'h0);
        rd(8'h20, 32'h440, "R9 two bits set");
        wr(8'h20, 32'h040);
        rd(8'h20, 32'h400, "R9 clears only written bit");
        @(negedge clk); #1;
        chk("R10 irq kept", {31'h0, irq}, 32'h1);
        wr(8'h20, 32'h3FF);
        rd(8'h20, 32'h400, "R9 zero bit kept");
        wr(8'h20, 32'h400);
        rd(8'h20, 32'h0, "R9 cleared");
        @(negedge clk); #1;
        chk("R10 irq low", {31'h0, irq}, 32'h0);

        repeat (2) @(negedge clk);
        #2;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule